// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. The frame is built from a set of configuration inputs:

- **Character length:** 5 to 9 bits.
- **Parity:** six parity options.
- **Stop period:** set in quarter-bit steps.

A character is taken through a valid/ready handshake. From then on, the frame advances only on a bit-clock enable pulse (`tick`). That pulse runs at either 16 times or 1 times the bit rate, chosen by `mode_x16`.

A break control pulls the line low whenever it is set and overrides everything else. If break is raised during a frame, that frame is abandoned. A `busy` flag reports that a frame is in progress. The divisor that produces `tick` sits outside the block.

Top module: `async_tx`

## Requirements
- R1: After reset `txd` is high, `busy` is low and `in_ready` is high. While no frame is running and break is off, `txd` stays high.
- R2: A character is accepted on a clock edge where `in_valid` and `in_ready` are both high, and `busy` is high from the next cycle. The frame is a low start bit, then the data bits least significant first, then the parity bit if one is enabled, then a high stop period. `txd` shows each frame element one clock after the internal state enters it.
- R3: Character length: `len_ext`=1 gives 9 bits whatever `len_sel` holds. Otherwise the length is 5 + `len_sel` (00→5, 01→6, 10→7, 11→8). Data bits above the selected length are not sent and do not affect parity.
- R4: Parity is selected by `par_mode`: 0 none, 1 odd, 2 even, 3 always 1, 4 always 0, 5 the value of `in_soft_par` taken with the data. Codes 6 and 7 send no parity bit.
- R5: With `mode_x16`=1, each bit lasts 16 ticks. The stop period lasts Q quarter-bits (4 ticks each), where Q is set by `stop_sel`: codes 1 to 6 give Q = code + 2 (3/4 to 8/4), code 7 gives 8, and code 0 gives 6 for a 5-bit character and 8 otherwise.
- R6: With `mode_x16`=0, each bit lasts 1 tick. The stop period is a whole number of bits: 1 when the R5 quarter count Q is 4 or less, otherwise 2.
- R7: While `brk` is high, `txd` is low from the next clock onward and `in_ready` is low.
- R8: Raising `brk` in mid-frame ends the frame: `busy` is low one clock later. After `brk` falls, `txd` returns high and the interrupted character is never resumed.
- R9: Configuration inputs, `in_data` and `in_soft_par` are captured at acceptance. Changing them during a frame leaves that frame's bits and duration unchanged.
- R10: The frame advances only on clock edges where `tick` is high. With `tick` held low, `txd` and `busy` hold their values.
- R11: `busy` stays high for B·(1+N+P)+S cycles when `tick` is high every cycle. Here B is 16 or 1, N is the length, P is 1 with parity and 0 without, and S is the stop tick count. `in_ready` is low while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Bit-clock enable pulse |
| mode_x16 | input | 1 | 1: tick at 16x bit rate, 0: tick at bit rate |
| len_ext | input | 1 | Selects 9-bit characters |
| len_sel | input | 2 | Character length select for 5 to 8 bits |
| par_mode | input | 3 | Parity option |
| stop_sel | input | 3 | Stop period select |
| brk | input | 1 | Break: forces the line low |
| in_data | input | 9 | Character to send |
| in_soft_par | input | 1 | Parity bit supplied with the data (mode 5) |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Transmitter can take a character |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame in progress |

## Verification
The bench builds the block with its default oversampling ratio of 16, so a quarter bit is 4 ticks. This lets every quarter-step stop code be seen as an exact `busy` duration, including both outcomes of the length-dependent code. Frames are also run in the 1x mode, which exercises the rounding of stop periods to whole bits and single-tick bits. Most of the time `tick` is high every cycle, so the expected timing follows cycle by cycle. A run with `tick` held low shows that progress is gated.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

    localparam int MAX_BITS = 9;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } tx_state_e;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_SPACE = 3'd4,
        PAR_SOFT  = 3'd5
    } par_mode_e;

    typedef struct packed {
        logic [3:0]          nbits;
        logic                has_par;
        logic                par_bit;
        logic [MAX_BITS-1:0] data;
    } frame_t;

    function automatic logic [3:0] char_bits(input logic ext, input logic [1:0] sel);
        return ext ? 4'd9 : (4'd5 + {2'b00, sel});
    endfunction

    // stop period in quarter bits
    function automatic logic [3:0] stop_quarters(input logic [2:0] sel, input logic five);
        logic [3:0] q;
        case (sel)
            3'd0:    q = five ? 4'd6 : 4'd8;
            3'd7:    q = 4'd8;
            default: q = {1'b0, sel} + 4'd2;
        endcase
        return q;
    endfunction

endpackage

// File: rtl/async_tx_cfg.sv
module async_tx_cfg
    import async_tx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int TW  = $clog2(2*OVS+1)
) (
    input  logic                mode_x16,
    input  logic                len_ext,
    input  logic [1:0]          len_sel,
    input  logic [2:0]          par_mode,
    input  logic [2:0]          stop_sel,
    input  logic [MAX_BITS-1:0] data,
    input  logic                soft_par,
    output frame_t              frame,
    output logic [TW-1:0]       bit_ticks,
    output logic [TW-1:0]       stop_ticks
);
    localparam logic [TW-1:0] QTICKS = TW'(OVS / 4);

    logic [3:0]          nbits;
    logic [MAX_BITS-1:0] mask;
    logic [MAX_BITS-1:0] dmask;
    logic [3:0]          quarters;
    logic [TW-1:0]       q_w;

    always_comb begin
        nbits = char_bits(len_ext, len_sel);
        for (int i = 0; i < MAX_BITS; i++) begin
            mask[i] = (i < int'(nbits));
        end
        dmask = data & mask;

        frame.nbits = nbits;
        frame.data  = dmask;
        case (par_mode_e'(par_mode))
            PAR_ODD:   begin frame.has_par = 1'b1; frame.par_bit = ~^dmask;  end
            PAR_EVEN:  begin frame.has_par = 1'b1; frame.par_bit = ^dmask;   end
            PAR_MARK:  begin frame.has_par = 1'b1; frame.par_bit = 1'b1;     end
            PAR_SPACE: begin frame.has_par = 1'b1; frame.par_bit = 1'b0;     end
            PAR_SOFT:  begin frame.has_par = 1'b1; frame.par_bit = soft_par; end
            default:   begin frame.has_par = 1'b0; frame.par_bit = 1'b0;     end
        endcase

        quarters  = stop_quarters(stop_sel, nbits == 4'd5);
        q_w       = TW'(quarters);
        bit_ticks = mode_x16 ? TW'(OVS) : TW'(1);
        if (mode_x16) begin
            stop_ticks = q_w * QTICKS;
        end else begin
            stop_ticks = (quarters <= 4'd4) ? TW'(1) : TW'(2);
        end
    end
endmodule

// File: rtl/async_tx_core.sv
module async_tx_core
    import async_tx_pkg::*;
#(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          brk,
    input  logic          accept,
    input  frame_t        frame_in,
    input  logic [TW-1:0] bit_ticks,
    input  logic [TW-1:0] stop_ticks,
    output logic          busy,
    output logic          txd
);
    tx_state_e           state;
    frame_t              fr_q;
    logic [MAX_BITS-1:0] sh_q;
    logic [3:0]          idx_q;
    logic [TW-1:0]       cnt_q;
    logic [TW-1:0]       bit_q;
    logic [TW-1:0]       stop_q;
    logic                txd_q;
    logic                line;
    logic [TW-1:0]       limit;
    logic                last;

    always_comb begin
        case (state)
            ST_START: line = 1'b0;
            ST_DATA:  line = sh_q[0];
            ST_PAR:   line = fr_q.par_bit;
            default:  line = 1'b1;
        endcase
        limit = (state == ST_STOP) ? stop_q : bit_q;
        last  = (cnt_q == limit - TW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            fr_q   <= '0;
            sh_q   <= '0;
            idx_q  <= '0;
            cnt_q  <= '0;
            bit_q  <= '0;
            stop_q <= '0;
            txd_q  <= 1'b1;
        end else begin
            txd_q <= brk ? 1'b0 : line;
            if (brk) begin
                state <= ST_IDLE;
                cnt_q <= '0;
            end else if (state == ST_IDLE) begin
                if (accept) begin
                    fr_q   <= frame_in;
                    sh_q   <= frame_in.data;
                    bit_q  <= bit_ticks;
                    stop_q <= stop_ticks;
                    idx_q  <= '0;
                    cnt_q  <= '0;
                    state  <= ST_START;
                end
            end else if (tick) begin
                if (!last) begin
                    cnt_q <= cnt_q + TW'(1);
                end else begin
                    cnt_q <= '0;
                    case (state)
                        ST_START: begin
                            state <= ST_DATA;
                            idx_q <= '0;
                        end
                        ST_DATA: begin
                            sh_q <= sh_q >> 1;
                            if (idx_q == fr_q.nbits - 4'd1) begin
                                state <= fr_q.has_par ? ST_PAR : ST_STOP;
                            end else begin
                                idx_q <= idx_q + 4'd1;
                            end
                        end
                        ST_PAR:  state <= ST_STOP;
                        default: state <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    assign busy = (state != ST_IDLE);
    assign txd  = txd_q;
endmodule

// File: rtl/async_tx.sv
module async_tx
    import async_tx_pkg::*;
#(
    parameter int OVS = 16,
    localparam int TW = $clog2(2*OVS+1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                mode_x16,
    input  logic                len_ext,
    input  logic [1:0]          len_sel,
    input  logic [2:0]          par_mode,
    input  logic [2:0]          stop_sel,
    input  logic                brk,
    input  logic [MAX_BITS-1:0] in_data,
    input  logic                in_soft_par,
    input  logic                in_valid,
    output logic                in_ready,
    output logic                txd,
    output logic                busy
);
    frame_t        frame_w;
    logic [TW-1:0] bit_ticks_w;
    logic [TW-1:0] stop_ticks_w;
    logic          accept;

    assign in_ready = !busy && !brk;
    assign accept   = in_valid && in_ready;

    async_tx_cfg #(.OVS(OVS), .TW(TW)) u_cfg (
        .mode_x16   (mode_x16),
        .len_ext    (len_ext),
        .len_sel    (len_sel),
        .par_mode   (par_mode),
        .stop_sel   (stop_sel),
        .data       (in_data),
        .soft_par   (in_soft_par),
        .frame      (frame_w),
        .bit_ticks  (bit_ticks_w),
        .stop_ticks (stop_ticks_w)
    );

    async_tx_core #(.TW(TW)) u_core (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .brk        (brk),
        .accept     (accept),
        .frame_in   (frame_w),
        .bit_ticks  (bit_ticks_w),
        .stop_ticks (stop_ticks_w),
        .busy       (busy),
        .txd        (txd)
    );
endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic brk,
    input logic in_valid,
    input logic in_ready,
    input logic txd,
    input logic busy
);
    assert_brk_low_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(brk)) |-> !txd);

    assert_abort_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(brk)) |-> !busy);

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !busy && !$past(busy) && !$past(brk)) |-> txd);

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid && in_ready)) |-> busy);

    assert_no_tick_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(busy) && !$past(tick) && !$past(brk)) |-> busy);

    assert_ready_busy_R11: assert property (@(posedge clk) disable iff (rst)
        busy |-> !in_ready);
endmodule

bind async_tx async_tx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .brk      (brk),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .txd      (txd),
    .busy     (busy)
);

// File: tb/tb_async_tx.sv
module tb_async_tx;
    logic       clk = 1'b0;
    logic       rst;
    logic       tick;
    logic       mode_x16;
    logic       len_ext;
    logic [1:0] len_sel;
    logic [2:0] par_mode;
    logic [2:0] stop_sel;
    logic       brk;
    logic [8:0] in_data;
    logic       in_soft_par;
    logic       in_valid;
    logic       in_ready;
    logic       txd;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    async_tx dut (
        .clk(clk), .rst(rst), .tick(tick), .mode_x16(mode_x16),
        .len_ext(len_ext), .len_sel(len_sel), .par_mode(par_mode),
        .stop_sel(stop_sel), .brk(brk), .in_data(in_data),
        .in_soft_par(in_soft_par), .in_valid(in_valid),
        .in_ready(in_ready), .txd(txd), .busy(busy)
    );

    // {x16, ext, len[1:0], par[2:0], stop[2:0], data[8:0], soft, has_par, par, stop_ticks[5:0]}
    localparam int NV = 11;
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 1'b0, 2'd3, 3'd0, 3'd2, 9'h0A5, 1'b0, 1'b0, 1'b0, 6'd16},
        {1'b1, 1'b0, 2'd3, 3'd1, 3'd1, 9'h0A5, 1'b0, 1'b1, 1'b1, 6'd12},
        {1'b1, 1'b0, 2'd2, 3'd2, 3'd6, 9'h007, 1'b0, 1'b1, 1'b1, 6'd32},
        {1'b1, 1'b0, 2'd0, 3'd3, 3'd0, 9'h01F, 1'b0, 1'b1, 1'b1, 6'd24},
        {1'b1, 1'b0, 2'd1, 3'd4, 3'd0, 9'h03F, 1'b0, 1'b1, 1'b0, 6'd32},
        {1'b1, 1'b1, 2'd2, 3'd5, 3'd3, 9'h155, 1'b1, 1'b1, 1'b1, 6'd20},
        {1'b1, 1'b1, 2'd0, 3'd2, 3'd7, 9'h1FF, 1'b0, 1'b1, 1'b1, 6'd32},
        {1'b0, 1'b0, 2'd3, 3'd1, 3'd1, 9'h000, 1'b0, 1'b1, 1'b1, 6'd1},
        {1'b0, 1'b0, 2'd0, 3'd0, 3'd0, 9'h015, 1'b0, 1'b0, 1'b0, 6'd2},
        {1'b0, 1'b0, 2'd3, 3'd0, 3'd5, 9'h03C, 1'b0, 1'b0, 1'b0, 6'd2},
        {1'b1, 1'b0, 2'd0, 3'd2, 3'd4, 9'h1E0, 1'b0, 1'b1, 1'b0, 6'd24}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Sends one frame and checks its bits and busy duration (R2-R6, R9, R11).
    task automatic run_frame(input logic [27:0] v, input bit scramble, input string tag);
        int n, p, b, stp, total, nb, bcnt, last_j;
        logic [11:0] expv;
        b    = v[27] ? 16 : 1;
        n    = v[26] ? 9 : 5 + int'(v[25:24]);
        p    = int'(v[7]);
        stp  = int'(v[5:0]);
        total = b * (1 + n + p) + stp;
        nb   = 2 + n + p;
        expv = '1;
        expv[0] = 1'b0;
        for (int k = 0; k < n; k++) expv[k+1] = v[9+k];
        if (p == 1) expv[n+1] = v[6];
        last_j = 1 + b * (nb - 1) + b / 2;

        mode_x16 = v[27]; len_ext = v[26]; len_sel = v[25:24];
        par_mode = v[23:21]; stop_sel = v[20:18]; in_data = v[17:9];
        in_soft_par = v[8]; in_valid = 1'b1;
        check({tag, " R11 ready before accept"}, int'(in_ready), 1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        bcnt = busy ? 1 : 0;
        for (int j = 1; j < 400; j++) begin
            @(negedge clk);
            if (scramble && j == 30) begin
                len_ext = 1'b1; par_mode = 3'd1; stop_sel = 3'd6;
                in_data = ~in_data; in_soft_par = 1'b1; mode_x16 = ~mode_x16;
            end
            if (busy) bcnt++;
            for (int k = 0; k < nb; k++) begin
                if (j == 1 + b * k + b / 2)
                    check($sformatf("%s R2/R3/R4 bit %0d", tag, k), int'(txd), int'(expv[k]));
            end
            if (!busy && j >= last_j) break;
        end
        check({tag, " R5/R6/R11 busy length"}, bcnt, total);
        @(negedge clk);
        check({tag, " R1 idle line"}, int'(txd), 1);
        check({tag, " R1 ready after"}, int'(in_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tick = 1'b1; mode_x16 = 1'b1; len_ext = 1'b0; len_sel = 2'd3;
        par_mode = 3'd0; stop_sel = 3'd2; brk = 1'b0; in_data = '0;
        in_soft_par = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset txd", int'(txd), 1);
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset ready", int'(in_ready), 1);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            run_frame(VEC[i], 1'b0, $sformatf("vec%0d", i));
            repeat (2) @(negedge clk);
        end

        // R9: inputs changed mid-frame
        run_frame(VEC[0], 1'b1, "R9 midframe");
        repeat (2) @(negedge clk);

        // R10: no progress without tick
        tick = 1'b0;
        mode_x16 = 1'b1; len_ext = 1'b0; len_sel = 2'd3; par_mode = 3'd0;
        stop_sel = 3'd2; in_data = 9'h0FF; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (40) @(negedge clk);
        check("R10 busy held", int'(busy), 1);
        check("R10 start held", int'(txd), 0);
        tick = 1'b1;
        repeat (16 * 9 + 16 + 2) @(negedge clk);
        check("R10 finishes after tick", int'(busy), 0);
        check("R10 idle line", int'(txd), 1);

        // R7: break while idle
        brk = 1'b1;
        @(negedge clk);
        check("R7 break idle txd", int'(txd), 0);
        check("R7 break ready", int'(in_ready), 0);
        brk = 1'b0;
        @(negedge clk);
        check("R1 after break idle", int'(txd), 1);

        // R8: break mid-frame
        in_data = 9'h000; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (40) @(negedge clk);
        brk = 1'b1;
        @(negedge clk);
        check("R7 break mid txd", int'(txd), 0);
        check("R8 break abort busy", int'(busy), 0);
        repeat (20) @(negedge clk);
        check("R7 break held txd", int'(txd), 0);
        check("R7 break held ready", int'(in_ready), 0);
        brk = 1'b0;
        @(negedge clk);
        check("R8 release txd", int'(txd), 1);
        check("R8 release ready", int'(in_ready), 1);
        repeat (60) @(negedge clk);
        check("R8 discarded busy", int'(busy), 0);
        check("R8 discarded txd", int'(txd), 1);

        // normal frame after break
        run_frame(VEC[1], 1'b0, "R8 post-break");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule